// File: doc/BRIEF.md
# Burst Prefetch Read Engine

This block sits between a host read port and a slow local bus that returns one word per clock from sequential word addresses. When the host asks for a word and the internal buffer is empty, the engine starts a burst. The burst reads a fixed number of consecutive local-bus words at one word per clock and writes them into a 16-entry first-in-first-out buffer. The host is held with a wait signal until the first word arrives. Later host reads come straight from the buffer, with no local-bus traffic, until the buffer is empty again.

The local-bus address counter keeps running from one burst to the next, so a sequence of bursts sweeps one contiguous address region. An abort input empties the buffer and sends the sequencer back to idle in the middle of a burst. The address counter keeps its value, so the next burst continues after the last word that was actually fetched. The local bus is modelled as combinational: a word presented on `lb_rdata` during a cycle with `lb_rd` high is captured at the end of that cycle.

Top module: `burst_prefetch_reader`

## Requirements
- R1: After reset, `lb_rd` is low, `lb_addr` equals START_ADDR (default 0), and `host_wait` is low while `host_req` is low.
- R2: A host request made while the buffer is empty and the sequencer is idle raises `host_wait` in the same cycle. It issues no local read in that cycle, and `lb_rd` goes high in the following cycle.
- R3: A burst consists of exactly BURST_LEN (default 16) cycles with `lb_rd` high, one per clock, with no gap while the buffer has room. `lb_addr` rises by one word on each of these cycles. `lb_rd` is low in the cycle after the last one.
- R4: `host_wait` stays high while the host requests and the buffer is empty. In the cycle after the first local read of a burst, `host_wait` is low and `host_data` equals the word fetched from the burst's start address.
- R5: While the buffer holds data, each host request cycle pops one word, in the order the words were fetched, with `host_wait` low. The sequencer starts no new burst until the buffer is empty.
- R6: No local read is issued while the buffer is full. A full buffer that has only been partly drained does not restart fetching.
- R7: Each burst starts at the word address that follows the last word fetched by the previous burst, so consecutive bursts cover contiguous addresses.
- R8: While `abort` is high, `lb_rd` is low and no word is popped. After it, the buffer is empty, the sequencer is idle, and the next burst starts at the word after the last one actually fetched.
- R9: `host_wait` is never high while `host_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host wants one word this cycle |
| host_wait | output | 1 | Host request cannot complete this cycle |
| host_data | output | 32 | Word delivered when `host_req` is high and `host_wait` is low |
| abort | input | 1 | Flush the buffer and stop the current burst |
| lb_rd | output | 1 | Local-bus read strobe, one word per cycle |
| lb_addr | output | 28 | Local-bus word address |
| lb_rdata | input | 32 | Local-bus read data, valid in the strobe cycle |

## Verification
The assertions assume that the local bus always returns data in the same cycle as the strobe and never stalls. They also assume that `abort` is a pulse which may arrive at any point of a burst. Under those conditions they require strict address stepping, no fetch into a full buffer, and an idle sequencer whenever data is waiting. The directed stimulus drives the local bus with a pure function of the address, which meets the first assumption. It raises `abort` only for a single cycle in the middle of a burst. Host requests are either held through whole drains or pulsed once to start a burst, so both the stalled-first-read case and the fill-to-full case occur.

// File: rtl/bpf_pkg.sv
// Shared types for the burst prefetch read engine.
package bpf_pkg;
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_FETCH = 1'b1
    } seq_state_e;
endpackage

// File: rtl/bpf_fifo.sv
// Synchronous first-in-first-out buffer with an extra wrap bit on each pointer.
// Assumes DEPTH is a power of two. Full and empty are decoded from the pointers
// without registers. A push when full or a pop when empty is ignored, and flush
// clears both pointers.
module bpf_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Status flags decoded from the pointer pair.
    always_comb begin
        empty   = (wr_ptr == rd_ptr);
        full    = (wr_ptr[IDX_W-1:0] == rd_ptr[IDX_W-1:0]) &&
                  (wr_ptr[IDX_W] != rd_ptr[IDX_W]);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        head    = store[rd_ptr[IDX_W-1:0]];
    end

    // Data storage; written only when a push is accepted.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr[IDX_W-1:0]] <= push_data;
        end
    end

    // Pointer update with flush taking priority over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/bpf_seq.sv
// Local-bus master sequencer. It leaves idle only when the host requests and
// the buffer is empty. It then issues BURST_LEN sequential reads, pausing while
// the buffer is full. The address counter is never rewound, so bursts tile one
// contiguous region. Assumes BURST_LEN >= 2 and a local bus that needs no wait states.
module bpf_seq
    import bpf_pkg::*;
#(
    parameter int                ADDR_W     = 28,
    parameter int                BURST_LEN  = 16,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              abort,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              lb_rd,
    output logic [ADDR_W-1:0] lb_addr,
    output logic              busy
);
    localparam int               CNT_W = $clog2(BURST_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BURST_LEN - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] beat;

    // Strobe whenever a burst is active, there is room, and no abort is pending.
    always_comb begin
        busy  = (state == SEQ_FETCH);
        lb_rd = busy && !fifo_full && !abort;
    end

    // Burst state and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= SEQ_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (host_req && fifo_empty) begin
                        state <= SEQ_FETCH;
                        beat  <= '0;
                    end
                end
                SEQ_FETCH: begin
                    if (lb_rd) begin
                        if (beat == LAST) begin
                            state <= SEQ_IDLE;
                            beat  <= '0;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Word address advances once per issued read and survives aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_addr <= START_ADDR;
        end else if (lb_rd) begin
            lb_addr <= lb_addr + 1'b1;
        end
    end
endmodule

// File: rtl/bpf_host_port.sv
// Host-side read port. A request completes in the same cycle when the buffer
// has data and no abort is present; otherwise the host sees wait.
module bpf_host_port (
    input  logic host_req,
    input  logic abort,
    input  logic fifo_empty,
    output logic pop,
    output logic host_wait
);
    // Accept a pop or stall the requester.
    always_comb begin
        pop       = host_req && !fifo_empty && !abort;
        host_wait = host_req && !pop;
    end
endmodule

// File: rtl/burst_prefetch_reader.sv
// Burst prefetch read engine top. It joins the host port, the sequencer and the
// buffer. The buffer captures local-bus data in the strobe cycle, so the local
// bus is assumed to answer combinationally.
module burst_prefetch_reader #(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 28,
    parameter int                DEPTH      = 16,
    parameter int                BURST_LEN  = 16,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    output logic              host_wait,
    output logic [DATA_W-1:0] host_data,
    input  logic              abort,
    output logic              lb_rd,
    output logic [ADDR_W-1:0] lb_addr,
    input  logic [DATA_W-1:0] lb_rdata
);
    logic fifo_full;
    logic fifo_empty;
    logic fifo_pop;
    logic seq_busy;

    bpf_host_port u_host (
        .host_req  (host_req),
        .abort     (abort),
        .fifo_empty(fifo_empty),
        .pop       (fifo_pop),
        .host_wait (host_wait)
    );

    bpf_seq #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN),
        .START_ADDR(START_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .abort     (abort),
        .fifo_empty(fifo_empty),
        .fifo_full (fifo_full),
        .lb_rd     (lb_rd),
        .lb_addr   (lb_addr),
        .busy      (seq_busy)
    );

    bpf_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (abort),
        .push     (lb_rd),
        .push_data(lb_rdata),
        .pop      (fifo_pop),
        .head     (host_data),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );
endmodule

// File: rtl/bpf_checker.sv
// Protocol checker for the burst prefetch read engine, bound to the top.
module bpf_checker #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_wait,
    input logic              abort,
    input logic              lb_rd,
    input logic [ADDR_W-1:0] lb_addr,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              seq_busy
);
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rd |=> (lb_addr == ADDR_W'($past(lb_addr) + 1'b1)));

    p_wait_on_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && fifo_empty) |-> host_wait);

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !fifo_empty && !abort) |=> !seq_busy);

    p_no_fetch_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !lb_rd);

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!lb_rd && fifo_empty));

    p_no_wait_unreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req |-> !host_wait);
endmodule

bind burst_prefetch_reader bpf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_wait (host_wait),
    .abort     (abort),
    .lb_rd     (lb_rd),
    .lb_addr   (lb_addr),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .seq_busy  (seq_busy)
);

// File: tb/burst_prefetch_reader_tb.sv
// Directed bench: inputs change just after a rising edge, outputs are checked
// on the falling edge. The local bus returns a fixed function of the address.
module burst_prefetch_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wait;
    logic [31:0] host_data;
    logic        abort = 1'b0;
    logic        lb_rd;
    logic [27:0] lb_addr;
    logic [31:0] lb_rdata;
    int          vectors = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] word_of(input int a);
        logic [27:0] w;
        w = 28'(a);
        return {w[3:0], w} ^ 32'h5A5A_0000;
    endfunction

    assign lb_rdata = word_of(int'(lb_addr));

    burst_prefetch_reader u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_req (host_req),
        .host_wait(host_wait),
        .host_data(host_data),
        .abort    (abort),
        .lb_rd    (lb_rd),
        .lb_addr  (lb_addr),
        .lb_rdata (lb_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    // R1 and R9: idle outputs after reset.
    task automatic t_reset();
        host_req = 1'b0;
        @(negedge clk);
        chk("R1 lb_rd", 32'(lb_rd), 32'd0);
        chk("R1 lb_addr", 32'(lb_addr), 32'd0);
        chk("R9 host_wait", 32'(host_wait), 32'd0);
        next_cycle();
    endtask

    // R2, R3, R4: start a burst at s; optionally hold the request for the first word.
    task automatic fire_burst(input int s, input bit take_first);
        host_req = 1'b1;
        @(negedge clk);
        chk("R2 wait on empty", 32'(host_wait), 32'd1);
        chk("R2 no read in request cycle", 32'(lb_rd), 32'd0);
        next_cycle();
        host_req = take_first;
        @(negedge clk);
        chk("R2 read follows", 32'(lb_rd), 32'd1);
        chk("R3/R7 start address", 32'(lb_addr), 32'(s));
        if (take_first) chk("R4 still waiting", 32'(host_wait), 32'd1);
        next_cycle();
        @(negedge clk);
        if (take_first) begin
            chk("R4 wait released", 32'(host_wait), 32'd0);
            chk("R4 first word", host_data, word_of(s));
        end
        chk("R3 beat 1", 32'(lb_rd), 32'd1);
        chk("R3 addr 1", 32'(lb_addr), 32'(s + 1));
        next_cycle();
        host_req = 1'b0;
        for (int k = 2; k < 16; k++) begin
            @(negedge clk);
            chk("R3 beat", 32'(lb_rd), 32'd1);
            chk("R3 addr", 32'(lb_addr), 32'(s + k));
            next_cycle();
        end
        @(negedge clk);
        chk("R3 burst ends", 32'(lb_rd), 32'd0);
        next_cycle();
    endtask

    // R5: pop n words starting with the word fetched from address s.
    task automatic drain(input int s, input int n);
        for (int k = 0; k < n; k++) begin
            host_req = 1'b1;
            @(negedge clk);
            chk("R5 no wait", 32'(host_wait), 32'd0);
            chk("R5 data order", host_data, word_of(s + k));
            chk("R5 no local read", 32'(lb_rd), 32'd0);
            next_cycle();
        end
        host_req = 1'b0;
        @(negedge clk);
        chk("R5 idle after drain", 32'(lb_rd), 32'd0);
        chk("R9 no wait unrequested", 32'(host_wait), 32'd0);
        next_cycle();
    endtask

    // R6 and R7: fill to full, then show that a partial drain does not refetch.
    task automatic t_full_hold();
        fire_burst(16, 1'b0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R6 no fetch while full", 32'(lb_rd), 32'd0);
            next_cycle();
        end
        host_req = 1'b1;
        @(negedge clk);
        chk("R6 pop from full", host_data, word_of(16));
        next_cycle();
        host_req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R6 no refill before empty", 32'(lb_rd), 32'd0);
            next_cycle();
        end
        drain(17, 15);
    endtask

    // R8: abort in mid-burst, then the next burst resumes after the last fetched word.
    task automatic t_abort();
        host_req = 1'b1;
        @(negedge clk);
        chk("R8 setup wait", 32'(host_wait), 32'd1);
        next_cycle();
        host_req = 1'b0;
        @(negedge clk);
        chk("R8 setup addr", 32'(lb_addr), 32'd32);
        next_cycle();
        @(negedge clk);
        chk("R8 setup addr 2", 32'(lb_addr), 32'd33);
        next_cycle();
        abort = 1'b1;
        @(negedge clk);
        chk("R8 no read during abort", 32'(lb_rd), 32'd0);
        next_cycle();
        abort = 1'b0;
        @(negedge clk);
        chk("R8 idle after abort", 32'(lb_rd), 32'd0);
        next_cycle();
        fire_burst(34, 1'b1);
        drain(35, 15);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        fire_burst(0, 1'b1);
        drain(1, 15);
        t_full_hold();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule